// File: doc/BRIEF.md
# Clock Source Crosspoint with Suspend Control

This block sits between four clock sources (a reference clock and three synthesized clocks) and the output stage of a clock generator. Each of the routed outputs carries a 2-bit selection field that picks one source. On top of the routed outputs there are two fixed outputs: a divided copy taken from synthesizer 1 and a buffered copy of the reference. The block decides, once per control clock, which sources may run and which outputs may drive.

Three controls act on it. An active-low output-enable pin places every output in high impedance. When the shutdown-enable bit is set, that same pin also stops every source. An active-low suspend pin turns off a masked set of synthesizers and a masked set of outputs. A synthesizer must not be suspended while an output that draws from it stays enabled. When the masks break this rule, an error flag is raised and the dependent output is held off regardless. After a shutdown, each synthesizer remains stopped until its lock indication returns. The clock selection itself is modelled as plain gated multiplexing.

Top module: `clk_xpt_susp`

## Requirements
- R1: `route_clk[o]` equals `src_clk[s] & src_run[s]`, where s is the field `sel_cfg[2o+1:2o]`. The encoding is 0 = reference, 1 = synth1, 2 = synth2, 3 = synth3.
- R2: One clock after `oe_pin` is sampled low, every bit of `out_en` is 0.
- R3: One clock after `oe_pin` is sampled low with `sd_en` = 1, every bit of `src_run` is 0. With `sd_en` = 0, a low `oe_pin` leaves `src_run` unchanged.
- R4: One clock after `susp_pin` is sampled low, synthesizer k (`src_run[k]`, k = 1..3) is 0 if `src_susp_mask[k-1]` is set. The suspend pin never stops the reference (`src_run[0]`).
- R5: One clock after `susp_pin` is sampled low, every `out_en[o]` whose `out_susp_mask[o]` bit is set is 0.
- R6: The source of an enable is as follows. Bits 0..NOUT-1 use their selection field. Bit NOUT uses synth1. Bit NOUT+1 uses the reference. An output enable is 1 only when its source's `src_run` is 1, so an output tied to a stopped or suspended source is forced off.
- R7: `cfg_err` is set one clock after the configuration has an output whose source is a synthesizer with its `src_susp_mask` bit set while that output's `out_susp_mask` bit is clear. This does not depend on the pins.
- R8: After a shutdown ends, the reference runs on the next clock. Synthesizer k stays stopped until `syn_lock[k-1]` is sampled high, and then runs on that same clock.
- R9: During reset, `out_en`, `src_run`, `cfg_err` and `route_clk` are all 0. Every synthesizer leaves reset waiting for its lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_clk | input | NSRC | Source clocks: bit 0 reference, bits 1..3 synthesizers |
| sel_cfg | input | NOUT*2 | Source selection field per routed output |
| oe_pin | input | 1 | Output enable, low = all outputs high impedance |
| susp_pin | input | 1 | Suspend, active low |
| sd_en | input | 1 | A low `oe_pin` also stops all sources |
| src_susp_mask | input | NSRC-1 | Synthesizers stopped during suspend |
| out_susp_mask | input | NOUT+2 | Outputs disabled during suspend |
| syn_lock | input | NSRC-1 | Lock indication per synthesizer |
| route_clk | output | NOUT | Selected, gated clock per routed output |
| out_en | output | NOUT+2 | Drive enable per output, 0 = high impedance |
| src_run | output | NSRC | Run enable per source |
| cfg_err | output | 1 | Suspend mask conflicts with routing |

## Verification
The bench builds the block with its defaults of four sources and four routed outputs. At that size, every one of the 256 routing settings can be swept against every synthesizer suspend mask and both suspend pin levels, under several output-mask patterns. This covers every source-to-output dependency that can raise the error flag or force an output off. A second sweep combines the output-enable pin with the shutdown-enable bit. A directed sequence then releases each synthesizer lock in turn after a shutdown.

// File: rtl/clk_xpt_pkg.sv
package clk_xpt_pkg;
  localparam int unsigned XPT_NSRC = 4;
  localparam int unsigned XPT_SELW = 2;

  typedef enum logic [XPT_SELW-1:0] {
    SRC_REF  = 2'd0,
    SRC_SYN1 = 2'd1,
    SRC_SYN2 = 2'd2,
    SRC_SYN3 = 2'd3
  } src_id_e;
endpackage

// File: rtl/clk_xpt_mux.sv
module clk_xpt_mux #(
  parameter int unsigned NSRC = 4,
  parameter int unsigned NOUT = 4,
  parameter int unsigned SELW = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]      src_clk,
  input  logic [NSRC-1:0]      src_gate,
  input  logic [NOUT*SELW-1:0] sel_cfg,
  output logic [NOUT-1:0]      route_clk
);
  for (genvar o = 0; o < NOUT; o++) begin : g_out
    logic [SELW-1:0] sel_o;
    assign sel_o        = sel_cfg[o*SELW +: SELW];
    assign route_clk[o] = src_clk[sel_o] & src_gate[sel_o];
  end
endmodule

// File: rtl/clk_src_ctrl.sv
module clk_src_ctrl #(
  parameter int unsigned NSRC = 4,
  localparam int unsigned NSYN = NSRC - 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            shutdown,
  input  logic            suspend,
  input  logic [NSYN-1:0] src_susp_mask,
  input  logic [NSYN-1:0] syn_lock,
  output logic [NSRC-1:0] run_nxt,
  output logic [NSRC-1:0] run_q
);
  logic [NSYN-1:0] wait_q;
  logic [NSYN-1:0] wait_nxt;

  // reference has no lock to wait for and ignores suspend
  assign run_nxt[0] = ~shutdown;

  for (genvar k = 0; k < NSYN; k++) begin : g_syn
    always_comb begin
      wait_nxt[k]  = shutdown | (wait_q[k] & ~syn_lock[k]);
      run_nxt[k+1] = ~(shutdown | (suspend & src_susp_mask[k]) | wait_nxt[k]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q <= '1;
      run_q  <= '0;
    end else begin
      wait_q <= wait_nxt;
      run_q  <= run_nxt;
    end
  end
endmodule

// File: rtl/clk_oe_ctrl.sv
module clk_oe_ctrl
  import clk_xpt_pkg::*;
#(
  parameter int unsigned NSRC = 4,
  parameter int unsigned NOUT = 4,
  parameter int unsigned SELW = $clog2(NSRC),
  localparam int unsigned NSYN = NSRC - 1,
  localparam int unsigned NEN  = NOUT + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 oe_pin,
  input  logic                 suspend,
  input  logic [NOUT*SELW-1:0] sel_cfg,
  input  logic [NSYN-1:0]      src_susp_mask,
  input  logic [NEN-1:0]       out_susp_mask,
  input  logic [NSRC-1:0]      run_nxt,
  output logic [NEN-1:0]       out_en,
  output logic                 cfg_err
);
  logic [NSRC-1:0] syn_mask_ext;
  logic [NEN-1:0]  en_nxt;
  logic [NEN-1:0]  bad_out;
  logic            err_nxt;

  assign syn_mask_ext = {src_susp_mask, 1'b0};

  for (genvar o = 0; o < NEN; o++) begin : g_en
    logic [SELW-1:0] src_o;
    if (o < NOUT) begin : g_routed
      assign src_o = sel_cfg[o*SELW +: SELW];
    end else if (o == NOUT) begin : g_syn1_div
      assign src_o = SELW'(SRC_SYN1);
    end else begin : g_ref_buf
      assign src_o = SELW'(SRC_REF);
    end
    always_comb begin
      en_nxt[o]  = oe_pin & ~(suspend & out_susp_mask[o]) & run_nxt[src_o];
      bad_out[o] = syn_mask_ext[src_o] & ~out_susp_mask[o];
    end
  end

  assign err_nxt = |bad_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_en  <= '0;
      cfg_err <= 1'b0;
    end else begin
      out_en  <= en_nxt;
      cfg_err <= err_nxt;
    end
  end
endmodule

// File: rtl/clk_xpt_susp.sv
module clk_xpt_susp #(
  parameter int unsigned NSRC = 4,
  parameter int unsigned NOUT = 4,
  localparam int unsigned SELW = $clog2(NSRC),
  localparam int unsigned NSYN = NSRC - 1,
  localparam int unsigned NEN  = NOUT + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NSRC-1:0]      src_clk,
  input  logic [NOUT*SELW-1:0] sel_cfg,
  input  logic                 oe_pin,
  input  logic                 susp_pin,
  input  logic                 sd_en,
  input  logic [NSYN-1:0]      src_susp_mask,
  input  logic [NEN-1:0]       out_susp_mask,
  input  logic [NSYN-1:0]      syn_lock,
  output logic [NOUT-1:0]      route_clk,
  output logic [NEN-1:0]       out_en,
  output logic [NSRC-1:0]      src_run,
  output logic                 cfg_err
);
  logic            shutdown;
  logic            suspend;
  logic [NSRC-1:0] run_nxt;

  assign shutdown = ~oe_pin & sd_en;
  assign suspend  = ~susp_pin;

  clk_src_ctrl #(.NSRC(NSRC)) u_src (
    .clk(clk), .rst_n(rst_n), .shutdown(shutdown), .suspend(suspend),
    .src_susp_mask(src_susp_mask), .syn_lock(syn_lock),
    .run_nxt(run_nxt), .run_q(src_run)
  );

  clk_oe_ctrl #(.NSRC(NSRC), .NOUT(NOUT), .SELW(SELW)) u_oe (
    .clk(clk), .rst_n(rst_n), .oe_pin(oe_pin), .suspend(suspend),
    .sel_cfg(sel_cfg), .src_susp_mask(src_susp_mask),
    .out_susp_mask(out_susp_mask), .run_nxt(run_nxt),
    .out_en(out_en), .cfg_err(cfg_err)
  );

  clk_xpt_mux #(.NSRC(NSRC), .NOUT(NOUT), .SELW(SELW)) u_mux (
    .src_clk(src_clk), .src_gate(src_run), .sel_cfg(sel_cfg),
    .route_clk(route_clk)
  );
endmodule

// File: rtl/clk_xpt_susp_chk.sv
module clk_xpt_susp_chk #(
  parameter int unsigned NSRC = 4,
  parameter int unsigned NOUT = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              oe_pin,
  input logic              susp_pin,
  input logic              sd_en,
  input logic [NSRC-2:0]   src_susp_mask,
  input logic [NOUT+1:0]   out_susp_mask,
  input logic [NOUT+1:0]   out_en,
  input logic [NSRC-1:0]   src_run
);
  AST_OE_LOW_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(oe_pin)) |-> (out_en == '0)); // R2

  AST_SHUTDOWN_STOPS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(oe_pin) && $past(sd_en)) |-> (src_run == '0)); // R3

  AST_SUSP_SRC_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(susp_pin)) |-> ((src_run[NSRC-1:1] & $past(src_susp_mask)) == '0)); // R4

  AST_SUSP_OUT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(susp_pin)) |-> ((out_en & $past(out_susp_mask)) == '0)); // R5

  AST_SYN1_DIV_NEEDS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    out_en[NOUT] |-> src_run[1]); // R6

  AST_REFBUF_NEEDS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    out_en[NOUT+1] |-> src_run[0]); // R6

  AST_REF_RUNS_AFTER_SD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && ($past(oe_pin) || !$past(sd_en))) |-> src_run[0]); // R8
endmodule

bind clk_xpt_susp clk_xpt_susp_chk #(.NSRC(NSRC), .NOUT(NOUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .oe_pin(oe_pin), .susp_pin(susp_pin),
  .sd_en(sd_en), .src_susp_mask(src_susp_mask),
  .out_susp_mask(out_susp_mask), .out_en(out_en), .src_run(src_run)
);

// File: tb/clk_xpt_susp_bench.sv
module clk_xpt_susp_bench;
  localparam int NSRC = 4;
  localparam int NOUT = 4;
  localparam int NEN  = NOUT + 2;

  logic            clk;
  logic            rst_n;
  logic [3:0]      src_clk;
  logic [7:0]      sel_cfg;
  logic            oe_pin, susp_pin, sd_en;
  logic [2:0]      src_susp_mask;
  logic [5:0]      out_susp_mask;
  logic [2:0]      syn_lock;
  logic [3:0]      route_clk;
  logic [5:0]      out_en;
  logic [3:0]      src_run;
  logic            cfg_err;

  int n_chk;
  int n_fail;
  logic [2:0] wait_m;
  string tag_en, tag_run;

  clk_xpt_susp #(.NSRC(NSRC), .NOUT(NOUT)) u_clk_xpt_susp (
    .clk(clk), .rst_n(rst_n), .src_clk(src_clk), .sel_cfg(sel_cfg),
    .oe_pin(oe_pin), .susp_pin(susp_pin), .sd_en(sd_en),
    .src_susp_mask(src_susp_mask), .out_susp_mask(out_susp_mask),
    .syn_lock(syn_lock), .route_clk(route_clk), .out_en(out_en),
    .src_run(src_run), .cfg_err(cfg_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (sel=%0h smask=%0h omask=%0h oe=%0b susp=%0b sd=%0b)",
               tag, act, exp, sel_cfg, src_susp_mask, out_susp_mask, oe_pin, susp_pin, sd_en);
    end
  endtask

  // one clock, then compare against the arithmetic model
  task automatic step_and_check();
    logic sd, sus;
    logic [3:0] run;
    logic [3:0] mext;
    logic [5:0] en;
    logic [3:0] rt;
    logic err;
    @(posedge clk);
    @(negedge clk);
    sd  = !oe_pin && sd_en;
    sus = !susp_pin;
    for (int k = 0; k < 3; k++) wait_m[k] = sd | (wait_m[k] & !syn_lock[k]);
    run[0] = !sd;
    for (int k = 0; k < 3; k++) run[k+1] = !(sd | (sus & src_susp_mask[k]) | wait_m[k]);
    mext = {src_susp_mask, 1'b0};
    err = 1'b0;
    for (int o = 0; o < NEN; o++) begin
      int s;
      s = (o < NOUT) ? int'(sel_cfg[o*2 +: 2]) : ((o == NOUT) ? 1 : 0);
      en[o] = oe_pin & !(sus & out_susp_mask[o]) & run[s];
      err   = err | (mext[s] & !out_susp_mask[o]);
      if (o < NOUT) rt[o] = src_clk[s] & run[s];
    end
    chk("R1 route", 32'(route_clk), 32'(rt));
    chk(tag_en, 32'(out_en), 32'(en));
    chk(tag_run, 32'(src_run), 32'(run));
    chk("R7 cfg_err", 32'(cfg_err), 32'(err));
  endtask

  initial begin
    #3_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [5:0] opat [4];
    n_chk = 0; n_fail = 0;
    opat[0] = 6'h00; opat[1] = 6'h3F; opat[2] = 6'h15; opat[3] = 6'h2A;
    rst_n = 1'b0; src_clk = 4'hF; sel_cfg = 8'hE4;
    oe_pin = 1'b1; susp_pin = 1'b1; sd_en = 1'b0;
    src_susp_mask = 3'b000; out_susp_mask = 6'h00; syn_lock = 3'b111;
    wait_m = 3'b111;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 out_en", 32'(out_en), 32'h0);
    chk("R9 src_run", 32'(src_run), 32'h0);
    chk("R9 cfg_err", 32'(cfg_err), 32'h0);
    chk("R9 route", 32'(route_clk), 32'h0);
    rst_n = 1'b1;
    tag_en = "R5,R6 out_en"; tag_run = "R4 src_run";
    step_and_check();

    // sweep: every routing x synth mask x suspend level x output pattern
    for (int sel = 0; sel < 256; sel++)
      for (int sm = 0; sm < 8; sm++)
        for (int sp = 0; sp < 2; sp++)
          for (int op = 0; op < 4; op++) begin
            sel_cfg = 8'(sel); src_susp_mask = 3'(sm);
            susp_pin = sp[0]; out_susp_mask = opat[op];
            src_clk = 4'(sel ^ (sm << 1) ^ op);
            step_and_check();
          end

    // output enable and shutdown combinations
    tag_en = "R2 out_en"; tag_run = "R3 src_run";
    for (int sel = 0; sel < 256; sel += 17)
      for (int mode = 0; mode < 8; mode++) begin
        sel_cfg = 8'(sel); oe_pin = mode[0]; sd_en = mode[1];
        susp_pin = mode[2]; src_susp_mask = 3'b101; out_susp_mask = 6'h21;
        src_clk = 4'(sel);
        step_and_check();
      end

    // relock sequence after a shutdown
    tag_en = "R8 out_en"; tag_run = "R8 src_run";
    susp_pin = 1'b1; src_susp_mask = 3'b000; out_susp_mask = 6'h00;
    sel_cfg = 8'hE4; src_clk = 4'hF;
    sd_en = 1'b1; oe_pin = 1'b0; syn_lock = 3'b000;
    step_and_check();
    oe_pin = 1'b1;
    step_and_check();
    chk("R8 ref only", 32'(src_run), 32'h1);
    step_and_check();
    for (int k = 0; k < 3; k++) begin
      syn_lock[k] = 1'b1;
      step_and_check();
      chk("R8 lock order", 32'(src_run), 32'((2 << k) - 1 | ((1 << (k + 2)) - 1)));
      syn_lock[k] = 1'b0;
      step_and_check();
    end
    chk("R8 all running", 32'(src_run), 32'hF);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule